// File: doc/BRIEF.md
# Virtual Partition Mapping Valid-Bit Register with Access Gate

The block holds a 64-bit register of valid flags, one flag for each virtual partition mapping entry. A flag marks whether the matching translation entry, kept in a separate set of mapping registers, may be used. Each mapping register carries four entries, so entry m sits in mapping register m>>2. The number of implemented mapping registers is a capability input. Flags beyond the implemented range, and the whole upper word, always read as zero.

The block also judges every system-register access aimed at it and gives exactly one outcome for each access. The outcome depends on the current privilege level, the feature and capability flags, three nested-virtualization control bits, a trap-lower control from the highest level, and two secure-debug undefined flags. The possible outcomes are: undefined, trap to level 2, trap to level 3, redirect to a memory offset, or direct register access. A one-pulse response carries the outcome, the read data, the exception class for traps and the memory offset for redirects. A side port lets a consumer ask whether a given entry is valid and which mapping register holds it.

Top module: `vpm_valid_gate`

## Requirements
- R1: A request is handled only when op0=2'b11, op1=3'b100, CRn=4'b1010, CRm=4'b0100 and op2=3'b001, and reads and writes use this same encoding. Any other request gives no response and leaves the register unchanged.
- R2: When neither feature flag is set, or the capability grant flag is clear, every access is undefined at every level.
- R3: An access from level 0 is undefined.
- R4: From level 1 with nested control bits {nv2,nv1,nv0} matching 1x1, the outcome is redirect, the memory offset output is 12'h938, and the register is not touched.
- R5: From level 1 with nv0 set but not the 1x1 pattern: when level 3 is present and trap-lower is set, the outcome is undefined if the secure-debug undef flag is set and trap to level 3 otherwise. In all other cases the outcome is trap to level 2. Both traps report exception class 6'h18.
- R6: From level 1 with nv0 clear, the access is undefined.
- R7: From level 2 the rules apply in this order. If level 3 is present and both the undef-priority flag and trap-lower are set, the access is undefined. Otherwise, if level 3 is present and trap-lower is set, the access is undefined when the secure-debug undef flag is set and traps to level 3 when it is clear. In every other case the access is direct.
- R8: From level 3 the access is always direct.
- R9: Bits [63:32] always read as zero, and writes to them have no effect.
- R10: Bit m reads as zero, and writes to it have no effect, when m >= (max_group+1)*4.
- R11: After reset the register reads as all zeros and no response is pending.
- R12: Each accepted request raises rsp_valid for exactly one cycle, on the cycle after the request, with exactly one outcome bit set. The register changes only on a direct write. A direct read returns the register value as it was before that cycle.
- R13: The entry query returns entry_group = entry_sel>>2, and entry_valid equals the masked flag of that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current privilege level 0..3 |
| feat_v0 | input | 1 | Early feature version implemented |
| feat_v1 | input | 1 | Full feature version implemented |
| cap_grant | input | 1 | Capability flag that grants this register |
| nv_ctl | input | 3 | Nested-virtualization bits {nv2,nv1,nv0} |
| el3_present | input | 1 | Level 3 is implemented |
| trap_lower | input | 1 | Level-3 control that traps lower-level accesses |
| sdd_undef | input | 1 | Secure-debug flag: a level-3 trap becomes undefined |
| sdd_undef_prio | input | 1 | Secure-debug flag: undefined takes priority at level 2 |
| max_group | input | 3 | Highest implemented mapping register index |
| entry_sel | input | 5 | Entry index for the query port |
| entry_valid | output | 1 | Masked valid flag of the selected entry |
| entry_group | output | 3 | Mapping register holding the selected entry |
| rsp_valid | output | 1 | Response pulse |
| rsp_undef | output | 1 | Outcome: undefined |
| rsp_trap_el2 | output | 1 | Outcome: trap to level 2 |
| rsp_trap_el3 | output | 1 | Outcome: trap to level 3 |
| rsp_redirect | output | 1 | Outcome: redirect to memory |
| rsp_direct | output | 1 | Outcome: direct register access |
| rsp_rdata | output | 64 | Read data on a direct read, else zero |
| rsp_ec | output | 6 | Exception class on traps, else zero |
| rsp_mem_offset | output | 12 | Memory offset on redirect, else zero |

## Verification
The outcome logic is swept over every combination of level, the two feature flags, the grant flag, all eight nested-control patterns, level-3 presence, trap-lower and both secure-debug flags. This separates the gating case from each level's own branch, and it separates the 1x1 redirect from the plain nv0 trap and from the cleared-nv0 undefined case. During the sweep, writes and reads alternate while max_group cycles through its values. A model register is checked against every direct read, which shows that only direct writes change the store. Separate patterns write all ones at the smallest and largest max_group, send requests that miss in each encoding field, and walk the query port over all 32 entries.

// File: rtl/vpm_gate_pkg.sv
// Package: shared outcome type and access encoding constants for the
// virtual partition mapping valid-bit gate.
package vpm_gate_pkg;

    // One outcome per accepted access.
    typedef enum logic [2:0] {
        OUT_UNDEF  = 3'd0,
        OUT_TRAP2  = 3'd1,
        OUT_TRAP3  = 3'd2,
        OUT_REDIR  = 3'd3,
        OUT_DIRECT = 3'd4
    } outcome_e;

    localparam logic [1:0]  ENC_OP0 = 2'b11;
    localparam logic [2:0]  ENC_OP1 = 3'b100;
    localparam logic [3:0]  ENC_CRN = 4'b1010;
    localparam logic [3:0]  ENC_CRM = 4'b0100;
    localparam logic [2:0]  ENC_OP2 = 3'b001;

    localparam logic [5:0]  TRAP_EC     = 6'h18;
    localparam logic [11:0] REDIR_OFFSET = 12'h938;

endpackage

// File: rtl/vpm_enc_match.sv
// Module: vpm_enc_match
// Compares a system-register encoding tuple against the one this block
// owns. Purely combinational; assumes the fields are stable while
// req_valid is high.
module vpm_enc_match
    import vpm_gate_pkg::*;
(
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);

    // Match all five fields at once; reads and writes share the tuple.
    always_comb begin
        hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN) &&
              (crm == ENC_CRM) && (op2 == ENC_OP2);
    end

endmodule

// File: rtl/vpm_access_decide.sv
// Module: vpm_access_decide
// Turns the privilege context into a single outcome for an access to the
// valid-bit register. Combinational; it assumes the caller gates the
// result with an encoding hit.
module vpm_access_decide
    import vpm_gate_pkg::*;
(
    input  logic [1:0] cur_el,
    input  logic       feat_v0,
    input  logic       feat_v1,
    input  logic       cap_grant,
    input  logic [2:0] nv_ctl,
    input  logic       el3_present,
    input  logic       trap_lower,
    input  logic       sdd_undef,
    input  logic       sdd_undef_prio,
    output outcome_e   outcome
);

    logic present;
    logic upper_trap;
    logic nv_redirect;

    // Shared terms: register presence, the level-3 trap request, and the
    // 1x1 nested pattern.
    always_comb begin
        present     = (feat_v0 || feat_v1) && cap_grant;
        upper_trap  = el3_present && trap_lower;
        nv_redirect = nv_ctl[2] && nv_ctl[0];
    end

    // Priority decision: presence first, then the branch for the level.
    always_comb begin
        outcome = OUT_UNDEF;
        if (!present) begin
            outcome = OUT_UNDEF;
        end else begin
            unique case (cur_el)
                2'd0: outcome = OUT_UNDEF;
                2'd1: begin
                    if (nv_redirect)
                        outcome = OUT_REDIR;
                    else if (nv_ctl[0])
                        outcome = upper_trap ? (sdd_undef ? OUT_UNDEF : OUT_TRAP3)
                                             : OUT_TRAP2;
                    else
                        outcome = OUT_UNDEF;
                end
                2'd2: begin
                    if (upper_trap && sdd_undef_prio)
                        outcome = OUT_UNDEF;
                    else if (upper_trap)
                        outcome = sdd_undef ? OUT_UNDEF : OUT_TRAP3;
                    else
                        outcome = OUT_DIRECT;
                end
                default: outcome = OUT_DIRECT;
            endcase
        end
    end

endmodule

// File: rtl/vpm_valid_store.sv
// Module: vpm_valid_store
// Holds the valid flags and applies the implemented-entry mask on both write
// and read. Bits at or above NUM_ENTRIES are never stored. Assumes max_group
// may change at any time; the read view follows its current value.
module vpm_valid_store #(
    parameter int REG_W       = 64,
    parameter int NUM_ENTRIES = 32,
    parameter int PER_GROUP   = 4,
    parameter int GROUP_W     = 3,
    localparam int SEL_W      = $clog2(NUM_ENTRIES),
    localparam int GSHIFT     = $clog2(PER_GROUP),
    localparam int LIM_W      = GROUP_W + 1 + GSHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [REG_W-1:0]   wdata,
    input  logic [GROUP_W-1:0] max_group,
    input  logic [SEL_W-1:0]   entry_sel,
    output logic [REG_W-1:0]   rd_value,
    output logic               entry_valid,
    output logic [SEL_W-GSHIFT-1:0] entry_group
);

    logic [NUM_ENTRIES-1:0] flags;
    logic [NUM_ENTRIES-1:0] impl_mask;
    logic [LIM_W-1:0]       limit;

    // Number of implemented entries: (max_group+1) groups of PER_GROUP.
    always_comb begin
        limit = LIM_W'((LIM_W'(max_group) + LIM_W'(1)) << GSHIFT);
    end

    // One mask bit per entry: implemented when its index is below limit.
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_mask
        assign impl_mask[i] = (32'(i) < 32'(limit));
    end

    // Storage: cleared on reset, masked update on a write enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else if (we)
            flags <= wdata[NUM_ENTRIES-1:0] & impl_mask;
    end

    // Read view: zero above the entry range and outside the implemented set.
    always_comb begin
        rd_value = '0;
        rd_value[NUM_ENTRIES-1:0] = flags & impl_mask;
    end

    // Entry query: containing mapping register and masked flag.
    always_comb begin
        entry_group = entry_sel[SEL_W-1:GSHIFT];
        entry_valid = flags[entry_sel] & impl_mask[entry_sel];
    end

    // R10: an unimplemented entry never reports valid.
    a_r10_query_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(entry_sel) >= 32'(limit)) |-> !entry_valid);

    // R12: storage holds its value without a write enable.
    a_r12_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flags));

endmodule

// File: rtl/vpm_valid_gate.sv
// Module: vpm_valid_gate (top)
// Virtual partition mapping valid-bit register plus its access gate. An
// accepted request produces one registered response pulse on the next
// cycle; the store updates on the same edge only for a direct write.
// Assumes requests are single-cycle strobes.
module vpm_valid_gate
    import vpm_gate_pkg::*;
#(
    parameter int REG_W       = 64,
    parameter int NUM_ENTRIES = 32,
    parameter int PER_GROUP   = 4,
    parameter int GROUP_W     = 3,
    localparam int SEL_W      = $clog2(NUM_ENTRIES),
    localparam int GSHIFT     = $clog2(PER_GROUP)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [1:0]               req_op0,
    input  logic [2:0]               req_op1,
    input  logic [3:0]               req_crn,
    input  logic [3:0]               req_crm,
    input  logic [2:0]               req_op2,
    input  logic [REG_W-1:0]         req_wdata,
    input  logic [1:0]               cur_el,
    input  logic                     feat_v0,
    input  logic                     feat_v1,
    input  logic                     cap_grant,
    input  logic [2:0]               nv_ctl,
    input  logic                     el3_present,
    input  logic                     trap_lower,
    input  logic                     sdd_undef,
    input  logic                     sdd_undef_prio,
    input  logic [GROUP_W-1:0]       max_group,
    input  logic [SEL_W-1:0]         entry_sel,
    output logic                     entry_valid,
    output logic [SEL_W-GSHIFT-1:0]  entry_group,
    output logic                     rsp_valid,
    output logic                     rsp_undef,
    output logic                     rsp_trap_el2,
    output logic                     rsp_trap_el3,
    output logic                     rsp_redirect,
    output logic                     rsp_direct,
    output logic [REG_W-1:0]         rsp_rdata,
    output logic [5:0]               rsp_ec,
    output logic [11:0]              rsp_mem_offset
);

    logic       enc_hit;
    logic       accept;
    logic       store_we;
    outcome_e   outcome;
    logic [REG_W-1:0] rd_value;

    vpm_enc_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (enc_hit)
    );

    vpm_access_decide u_decide (
        .cur_el         (cur_el),
        .feat_v0        (feat_v0),
        .feat_v1        (feat_v1),
        .cap_grant      (cap_grant),
        .nv_ctl         (nv_ctl),
        .el3_present    (el3_present),
        .trap_lower     (trap_lower),
        .sdd_undef      (sdd_undef),
        .sdd_undef_prio (sdd_undef_prio),
        .outcome        (outcome)
    );

    // Accept only owned encodings; write only when the access is direct.
    always_comb begin
        accept   = req_valid && enc_hit;
        store_we = accept && req_write && (outcome == OUT_DIRECT);
    end

    vpm_valid_store #(
        .REG_W       (REG_W),
        .NUM_ENTRIES (NUM_ENTRIES),
        .PER_GROUP   (PER_GROUP),
        .GROUP_W     (GROUP_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (store_we),
        .wdata       (req_wdata),
        .max_group   (max_group),
        .entry_sel   (entry_sel),
        .rd_value    (rd_value),
        .entry_valid (entry_valid),
        .entry_group (entry_group)
    );

    // Response register: one-hot outcome plus its payload, one cycle long.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_undef      <= 1'b0;
            rsp_trap_el2   <= 1'b0;
            rsp_trap_el3   <= 1'b0;
            rsp_redirect   <= 1'b0;
            rsp_direct     <= 1'b0;
            rsp_rdata      <= '0;
            rsp_ec         <= '0;
            rsp_mem_offset <= '0;
        end else begin
            rsp_valid      <= accept;
            rsp_undef      <= accept && (outcome == OUT_UNDEF);
            rsp_trap_el2   <= accept && (outcome == OUT_TRAP2);
            rsp_trap_el3   <= accept && (outcome == OUT_TRAP3);
            rsp_redirect   <= accept && (outcome == OUT_REDIR);
            rsp_direct     <= accept && (outcome == OUT_DIRECT);
            rsp_rdata      <= (accept && !req_write && outcome == OUT_DIRECT) ? rd_value : '0;
            rsp_ec         <= (accept && (outcome == OUT_TRAP2 || outcome == OUT_TRAP3)) ? TRAP_EC : '0;
            rsp_mem_offset <= (accept && outcome == OUT_REDIR) ? REDIR_OFFSET : '0;
        end
    end

    // R12: a response carries exactly one outcome, and none without a response.
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_undef, rsp_trap_el2, rsp_trap_el3,
                                  rsp_redirect, rsp_direct}) == 1);
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_undef || rsp_trap_el2 || rsp_trap_el3 ||
                         rsp_redirect || rsp_direct));

    // R3: level 0 never reaches anything but undefined.
    a_r3_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_el == 2'd0) |=> rsp_undef);

    // R8: level 3 with the register present is always direct.
    a_r8_el3_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_el == 2'd3 && (feat_v0 || feat_v1) && cap_grant) |=> rsp_direct);

    // R1: a miss on the encoding gives no response.
    a_r1_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !enc_hit) |=> !rsp_valid);

    // R9: the upper word of read data is always zero.
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[REG_W-1:NUM_ENTRIES] == '0);

    // R4: a redirect reports the fixed memory offset.
    a_r4_redirect_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redirect |-> rsp_mem_offset == 12'h938);

endmodule

// File: tb/vpm_valid_gate_bench.sv
module vpm_valid_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b100;
    logic [3:0]  req_crn = 4'b1010;
    logic [3:0]  req_crm = 4'b0100;
    logic [2:0]  req_op2 = 3'b001;
    logic [63:0] req_wdata = '0;
    logic [1:0]  cur_el = 2'd3;
    logic        feat_v0 = 1'b1, feat_v1 = 1'b0, cap_grant = 1'b1;
    logic [2:0]  nv_ctl = 3'b000;
    logic        el3_present = 1'b0, trap_lower = 1'b0, sdd_undef = 1'b0, sdd_undef_prio = 1'b0;
    logic [2:0]  max_group = 3'd7;
    logic [4:0]  entry_sel = '0;
    logic        entry_valid;
    logic [2:0]  entry_group;
    logic        rsp_valid, rsp_undef, rsp_trap_el2, rsp_trap_el3, rsp_redirect, rsp_direct;
    logic [63:0] rsp_rdata;
    logic [5:0]  rsp_ec;
    logic [11:0] rsp_mem_offset;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [63:0] model = '0;

    always #4 clk = ~clk;

    vpm_valid_gate u_vpm_valid_gate (.*);

    function automatic logic [63:0] mask_of(input logic [2:0] mg);
        int n = (int'(mg) + 1) * 4;
        logic [63:0] m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

    // Expected one-hot {direct, redirect, trap3, trap2, undef} from the rules.
    function automatic logic [4:0] expect_out(input logic [1:0] el, input logic f0, f1, cg,
                                              input logic [2:0] nv, input logic e3, tl, sd, sp);
        if (!((f0 | f1) & cg)) return 5'b00001;
        if (el == 0) return 5'b00001;
        if (el == 1) begin
            if (nv[2] & nv[0]) return 5'b01000;
            if (nv[0]) return (e3 & tl) ? (sd ? 5'b00001 : 5'b00100) : 5'b00010;
            return 5'b00001;
        end
        if (el == 2) begin
            if (e3 & sp & tl) return 5'b00001;
            if (e3 & tl) return sd ? 5'b00001 : 5'b00100;
            return 5'b10000;
        end
        return 5'b10000;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request; returns after the response cycle, sampled at a negedge.
    task automatic access(input logic wr, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic el3_read_check(input string tag, input logic [63:0] exp);
        cur_el = 3; feat_v0 = 1; cap_grant = 1;
        access(1'b0, '0);
        check(tag, {63'd0, rsp_direct, rsp_rdata}, {63'd0, 1'b1, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check("R11 no response after reset", {127'd0, rsp_valid}, '0);
        el3_read_check("R11 reads zero after reset", 64'd0);

        // R9 / R10: write all ones at the widest and narrowest entry ranges
        max_group = 7;
        access(1'b1, '1);
        el3_read_check("R9 upper word zero", 64'h0000_0000_FFFF_FFFF);
        max_group = 0;
        access(1'b1, '1);
        max_group = 7;
        el3_read_check("R10 only entries 0..3 stored", 64'h0000_0000_0000_000F);
        model = 64'hF;

        // R1: misses in each field give no response and no update
        for (int f = 0; f < 5; f++) begin
            req_op0 = (f == 0) ? 2'b10 : 2'b11;
            req_op1 = (f == 1) ? 3'b000 : 3'b100;
            req_crn = (f == 2) ? 4'b1011 : 4'b1010;
            req_crm = (f == 3) ? 4'b0101 : 4'b0100;
            req_op2 = (f == 4) ? 3'b000 : 3'b001;
            access(1'b1, '1);
            check("R1 miss gives no response", {127'd0, rsp_valid}, '0);
        end
        req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'b1010; req_crm = 4'b0100; req_op2 = 3'b001;
        el3_read_check("R1 miss leaves register", model);

        // Exhaustive context sweep: R2..R8, R12 with R10 masking
        for (int idx = 0; idx < 4096; idx++) begin
            logic [4:0] exp;
            logic [63:0] wd;
            logic [63:0] exp_rd;
            logic wr;
            string tag;
            cur_el = idx[1:0]; feat_v0 = idx[2]; feat_v1 = idx[3]; cap_grant = idx[4];
            nv_ctl = idx[7:5]; el3_present = idx[8]; trap_lower = idx[9];
            sdd_undef = idx[10]; sdd_undef_prio = idx[11];
            max_group = 3'((idx * 5) % 8);
            wr = idx[0] ^ idx[3] ^ idx[6];
            wd = {32'hDEAD_BEEF, 32'(idx * 32'h9E37_79B1)};
            exp = expect_out(cur_el, feat_v0, feat_v1, cap_grant, nv_ctl,
                             el3_present, trap_lower, sdd_undef, sdd_undef_prio);
            exp_rd = (exp[4] && !wr) ? (model & mask_of(max_group)) : 64'd0;
            if (!((feat_v0 | feat_v1) & cap_grant)) tag = "R2 gated";
            else if (cur_el == 0) tag = "R3 level0";
            else if (cur_el == 1 && nv_ctl[2] && nv_ctl[0]) tag = "R4 redirect";
            else if (cur_el == 1 && nv_ctl[0]) tag = "R5 level1 trap";
            else if (cur_el == 1) tag = "R6 level1 nv0 clear";
            else if (cur_el == 2) tag = "R7 level2 priority";
            else tag = "R8 level3 direct";
            access(wr, wd);
            check({tag, " outcome/data R12"},
                  {45'd0, rsp_valid, rsp_direct, rsp_redirect, rsp_trap_el3, rsp_trap_el2,
                   rsp_undef, rsp_ec, rsp_mem_offset, rsp_rdata},
                  {45'd0, 1'b1, exp, (exp[2] | exp[1]) ? 6'h18 : 6'h00,
                   exp[3] ? 12'h938 : 12'h000, exp_rd});
            if (exp[4] && wr) model = wd & mask_of(max_group);
            if (idx % 512 == 0) begin
                @(negedge clk);
                check("R12 pulse lasts one cycle", {127'd0, rsp_valid}, '0);
            end
        end

        // R13: query port walk over a known pattern
        cur_el = 3; feat_v0 = 1; cap_grant = 1; max_group = 7;
        access(1'b1, 64'hFFFF_FFFF_A5C3_96F0);
        model = 64'hA5C3_96F0;
        for (int mg = 0; mg < 8; mg += 5) begin
            max_group = 3'(mg);
            for (int s = 0; s < 32; s++) begin
                entry_sel = 5'(s);
                #1;
                check("R13 entry query", {124'd0, entry_group, entry_valid},
                      {124'd0, 3'(s >> 2), model[s] & (s < (mg + 1) * 4)});
            end
        end
        el3_read_check("R10 read masked at max_group 5", model & mask_of(3'd5));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule